// File: doc/BRIEF.md
# Boot-Loaded Lookup-Table Bus Translator

This block rewrites a data byte according to a set of control lines, using an arbitrary mapping held in on-chip RAM. It keeps no history, so a change to the mapping needs only a new table image and no change to the logic. The table is written into a serial flash that sits beside the chip. After reset the block reads the whole image from that flash and copies it into its RAM. While it does this it ignores its data inputs. When the last byte is in, it raises `ready` and from then on translates one word per clock.

The table address is the control value in the upper bits and the data value in the lower bits. Each entry is one output byte. With `CTRL_W = 6` and `DATA_W = 8` the table has 16384 entries, which is the target configuration. The parameter defaults use `CTRL_W = 2` (1024 entries) so that elaboration and the boot copy stay small. The flash read is one continuous transaction: read opcode 0x03, a 24-bit start address of zero, and then the table bytes in ascending address order. The serial link uses mode 0, with the clock idling low, MOSI changing on falling edges and MISO sampled on rising edges. `SCK_HALF` sets the number of system clocks in each half period of the serial clock.

Top module: `lut_xlat`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `ready`, `out_valid` and `out_data` go to 0, `spi_csn` goes to 1 and `spi_sclk` goes to 0.
- R2: After reset the block sends opcode 0x03 and then a 24-bit address of 0, MSB first, in mode 0. MOSI changes only while `spi_sclk` is low.
- R3: The block receives 2^(CTRL_W+DATA_W) bytes, MSB first, sampled on rising serial clock edges. Received byte k is stored at table entry k.
- R4: After the last data bit the block raises `spi_csn`. From the same edge `ready` is 1, and it stays 1 until the next reset.
- R5: When `in_valid` is sampled high with `ready` high, the next cycle shows `out_valid` = 1 and `out_data` = table entry {`in_ctrl`, `in_data`}, with the control value in the upper address bits.
- R6: Strobes sampled while `ready` is low are ignored. `out_valid` stays 0 and `out_data` stays 0.
- R7: After a cycle with no accepted strobe, `out_valid` is 0 and `out_data` keeps its previous value.
- R8: The result depends only on the address of the current strobe. Strobes may arrive on consecutive cycles, and each one yields its own entry.
- R9: `spi_csn` falls exactly once after reset, so the load is one unbroken transaction. `spi_sclk` is low whenever `spi_csn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | DATA_W | Data word to translate (low address bits) |
| in_ctrl | input | CTRL_W | Control lines (high address bits) |
| in_valid | input | 1 | Input strobe |
| out_data | output | DATA_W | Translated word, registered |
| out_valid | output | 1 | Pulses one cycle after an accepted strobe |
| ready | output | 1 | Table loaded, translation active |
| spi_sclk | output | 1 | Serial clock to flash, idles low |
| spi_csn | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Command/address to flash |
| spi_miso | input | 1 | Table data from flash |

## Verification
The assertions check on every cycle the timing relation between an accepted strobe and `out_valid`, the holding of `out_data` between strobes, and that the outputs stay quiet while `ready` is low. They also check that `ready` never drops, and the serial-bus rules: the clock stays low while chip select is high, MOSI is stable while the clock is high, and chip select rises only when loading ends. Only the bench's scenarios can show that the correct opcode and address went out, that exactly the right number of bits came in, and that every received byte landed at its own entry. The bench does this by sweeping all addresses against a flash model whose content it computes itself, and then by sending back-to-back, repeated and gapped strobes.

// File: rtl/lut_xlat_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the lookup-table translator.
package lut_xlat_pkg;
    localparam logic [7:0] FLASH_READ_OP = 8'h03;
    localparam int         HDR_BITS      = 32;   // opcode + 24-bit address

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_SHIFT,
        LD_DONE
    } ld_state_t;
endpackage

// File: rtl/lut_xlat_loader.sv
`timescale 1ns/1ps
// Boot loader: issues one serial-flash read from address 0 and streams
// N_BYTES bytes out as table writes, in ascending order.
// Assumes mode-0 flash, SCK_HALF >= 1, and that the flash presents each
// data bit after the falling edge that precedes its sampling edge.
module lut_xlat_loader
    import lut_xlat_pkg::*;
#(
    parameter int AW       = 10,
    parameter int SCK_HALF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          spi_sclk,
    output logic          spi_csn,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          done
);
    localparam int N_BYTES = 1 << AW;
    localparam int TOTAL   = HDR_BITS + 8 * N_BYTES;
    localparam int CW      = $clog2(TOTAL + 1);
    localparam int DIVW    = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    ld_state_t       st;
    logic [CW-1:0]   bit_cnt;
    logic [CW-1:0]   dbit;
    logic [DIVW-1:0] div_cnt;
    logic [31:0]     tx;
    logic [6:0]      rx;
    logic            tick;
    logic            data_phase;
    logic            last_bit;

    // Half-period tick and bit-position decode.
    always_comb begin
        tick       = (div_cnt == DIVW'(SCK_HALF - 1));
        dbit       = bit_cnt - CW'(HDR_BITS);
        data_phase = (bit_cnt >= CW'(HDR_BITS));
        last_bit   = (bit_cnt == CW'(TOTAL - 1));
    end

    assign spi_mosi = tx[31];
    assign done     = (st == LD_DONE);

    // Transaction sequencer: serial clock, shifting and table-write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= LD_IDLE;
            spi_csn  <= 1'b1;
            spi_sclk <= 1'b0;
            tx       <= '0;
            rx       <= '0;
            bit_cnt  <= '0;
            div_cnt  <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            case (st)
                LD_IDLE: begin
                    spi_csn <= 1'b0;
                    tx      <= {FLASH_READ_OP, 24'h000000};
                    div_cnt <= '0;
                    st      <= LD_SHIFT;
                end
                LD_SHIFT: begin
                    if (!tick) begin
                        div_cnt <= div_cnt + 1'b1;
                    end else begin
                        div_cnt <= '0;
                        if (!spi_sclk) begin
                            spi_sclk <= 1'b1;
                            rx       <= {rx[5:0], spi_miso};
                            if (data_phase && (bit_cnt[2:0] == 3'd7)) begin
                                wr_en   <= 1'b1;
                                wr_addr <= AW'(dbit >> 3);
                                wr_data <= {rx, spi_miso};
                            end
                        end else begin
                            spi_sclk <= 1'b0;
                            tx       <= {tx[30:0], 1'b0};
                            if (last_bit) begin
                                spi_csn <= 1'b1;
                                st      <= LD_DONE;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                end
                default: begin
                    spi_csn  <= 1'b1;
                    spi_sclk <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lut_xlat_ram.sv
`timescale 1ns/1ps
// Simple dual-port table RAM: one write port for the loader and one read
// port with a registered output that holds between reads.
// Assumes reads and writes never target the same cycle (the loader finishes
// before reads are enabled).
module lut_xlat_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Table write from the boot loader.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read; output cleared by reset and held when not reading.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/lut_xlat.sv
`timescale 1ns/1ps
// Lookup-table bus translator. After reset it copies the table from a serial
// flash into RAM, then maps {in_ctrl, in_data} to out_data with one cycle of
// latency. Stateless: each result depends only on its own address.
// Assumes the flash image holds 2^(CTRL_W+DATA_W) bytes starting at 0.
module lut_xlat #(
    parameter int DATA_W   = 8,
    parameter int CTRL_W   = 2,
    parameter int SCK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CTRL_W-1:0] in_ctrl,
    input  logic              in_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              ready,
    output logic              spi_sclk,
    output logic              spi_csn,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int AW = DATA_W + CTRL_W;

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_byte;
    logic          accept;

    lut_xlat_loader #(.AW(AW), .SCK_HALF(SCK_HALF)) u_loader (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_byte),
        .done(ready)
    );

    // Accept strobes only once the table is complete.
    assign accept = in_valid & ready;

    lut_xlat_ram #(.AW(AW), .DW(DATA_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .waddr(wr_addr), .wdata(DATA_W'(wr_byte)),
        .re(accept), .raddr({in_ctrl, in_data}),
        .rdata(out_data)
    );

    // Output strobe aligned with the registered table read.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= accept;
    end
endmodule

// File: rtl/lut_xlat_chk.sv
`timescale 1ns/1ps
// Protocol and timing checker for lut_xlat, attached by bind.
module lut_xlat_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              spi_sclk,
    input logic              spi_csn,
    input logic              spi_mosi
);
    p_mosi_mode0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    p_ready_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_csn_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> spi_csn);

    p_accept_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready) |=> out_valid);

    p_ignored_before_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!out_valid && out_data == '0));

    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && ready) |=> (!out_valid && $stable(out_data)));

    p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> !spi_sclk);

    p_single_txn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_csn) |-> ready);
endmodule

bind lut_xlat lut_xlat_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ready(ready),
    .out_valid(out_valid), .out_data(out_data),
    .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi)
);

// File: tb/tb_lut_xlat.sv
`timescale 1ns/1ps
module tb_lut_xlat;
    localparam int DW   = 8;
    localparam int CW   = 2;
    localparam int HALF = 2;
    localparam int AW   = DW + CW;
    localparam int N    = 1 << AW;
    localparam int HDR  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [CW-1:0] in_ctrl = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_valid, ready, spi_sclk, spi_csn, spi_mosi;
    logic          spi_miso = 1'b0;

    always #5 clk = ~clk;

    lut_xlat #(.DATA_W(DW), .CTRL_W(CW), .SCK_HALF(HALF)) dut (.*);

    int vectors = 0, miscompares = 0;
    bit finished = 0;
    bit exp_valid = 0;
    logic [DW-1:0] exp_data = '0;

    // Flash image content, computed by the bench.
    function automatic logic [7:0] img(int k);
        return 8'((k * 37) ^ (k >> 4) ^ 165);
    endfunction

    // ---- flash model ----
    int fbits = 0, csn_falls = 0, rises = 0, fidx;
    logic [31:0] fcmd = '0;
    logic [7:0]  fbyte;
    always @(negedge spi_csn) begin csn_falls++; fbits = 0; end
    always @(posedge spi_sclk) if (!spi_csn) begin
        if (fbits < HDR) fcmd = {fcmd[30:0], spi_mosi};
        fbits++; rises++;
    end
    always @(negedge spi_sclk) if (!spi_csn && fbits >= HDR) begin
        fidx = fbits - HDR;
        fbyte = img(fidx / 8);
        spi_miso = fbyte[7 - (fidx % 8)];
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // One clock: compare against the model, drive the next input, update model.
    task automatic step(bit v, int addr, string tag);
        @(negedge clk);
        chk({tag, " out_valid"}, 32'(out_valid), 32'(exp_valid));
        chk({tag, " out_data"},  32'(out_data),  32'(exp_data));
        if (spi_csn && spi_sclk) chk("R9 sclk idle", 1, 0);
        in_valid = v;
        in_ctrl  = CW'(addr >> DW);
        in_data  = DW'(addr);
        if (v && ready) begin
            exp_valid = 1;
            exp_data  = DW'(img(addr % N));
        end else begin
            exp_valid = 0;
        end
    endtask

    initial begin
        #(200000 * 10);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int guard;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(ready), 0);
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 out_data", 32'(out_data), 0);
        chk("R1 csn", 32'(spi_csn), 1);
        chk("R1 sclk", 32'(spi_sclk), 0);
        rst_n = 1'b1;

        // R6: random strobes during the load are ignored
        guard = 0;
        while (!ready && guard < 150000) begin
            step(1'($urandom), int'($urandom % N), "R6");
            guard++;
        end
        chk("R4 ready reached", 32'(ready), 1);
        chk("R4 csn released", 32'(spi_csn), 1);
        chk("R2 command+address", fcmd, 32'h03000000);
        chk("R3 bits clocked", 32'(rises), 32'(HDR + 8 * N));
        chk("R9 single transaction", 32'(csn_falls), 1);

        // R3/R8: back-to-back sweep of every entry
        for (int k = 0; k < N; k++) step(1, k, "R3");
        // R7: gaps, with inputs wiggling
        for (int k = 0; k < 6; k++) step(0, int'($urandom % N), "R7");
        // R5: boundary addresses
        step(1, 0, "R5"); step(1, N - 1, "R5"); step(0, 0, "R7");
        step(1, (N - 1) & ((1 << DW) - 1), "R5"); step(1, N - (1 << DW), "R5");
        // R8: repeated and alternating addresses
        for (int k = 0; k < 8; k++) step(1, 77, "R8");
        for (int k = 0; k < 8; k++) step(1, (k % 2) ? 300 : 5, "R8");
        // R5/R7: random mix
        for (int k = 0; k < 500; k++) step(1'($urandom), int'($urandom % N), "R5");
        step(0, 0, "R7"); step(0, 0, "R7");
        chk("R4 ready sticky", 32'(ready), 1);
        summary();
    end
endmodule